// File: doc/BRIEF.md
# Flag Offset Register File

This block stores the two thresholds used by a FIFO's programmable status flags: the almost-empty distance `n` and the almost-full distance `m`. Each threshold is split into a low byte and a narrow high part, giving four small registers. No address is used. A two-bit selector steps through the four registers in a fixed cycle. Software or a host loads the registers by holding the load strobe low while it presents words on the FIFO data input. It reads them back the same way, and the words appear on the FIFO data output.

The block runs on one clock, the tied read/write clock case. The selector is shared by loads and readbacks, and it keeps its position while the load strobe is high. A host can therefore update one or two registers, go back to normal FIFO traffic, and later continue with the register after the last one accessed. The assembled thresholds go to the flag comparators continuously. The width of each threshold is `log2(DEPTH)`, so the high part is `log2(DEPTH) - 8` bits wide and has no bits at all when the depth is 256.

Top module: `ofs_regfile`

## Requirements
- R1: While `rst_n` is low and after it rises, both thresholds are 7 (`0x007`), `rd_data` is 0, `err` is 0, and the selector points at the empty-threshold low byte.
- R2: At a clock edge where `ld_n`=0 and `wen1_n`=0 (and no readback is requested), the selected register takes `wr_data`. A low-byte register takes bits 7:0. A high register takes bits `HI_W-1:0`, where `HI_W = log2(DEPTH) - 8` (2 bits at the default depth of 1024).
- R3: Selector codes are 0 for empty low, 1 for empty high, 2 for full low and 3 for full high. Each access moves the selector to the next code, and after code 3 it returns to code 0.
- R4: With `ld_n`=0 and `wen1_n`=1 no register changes. With `ld_n`=1 neither `wen1_n` nor the read enables touch the registers or the selector.
- R5: A partial sequence is resumed where it stopped: raising `ld_n` keeps the selector. Loads and readbacks advance the same selector.
- R6: At a clock edge where `ld_n`=0, `ren1_n`=0 and `ren2_n`=0 (and no load is requested), `rd_data` takes the selected register, zero-extended. Otherwise `rd_data` holds its value.
- R7: Readback of a high register returns 0 in every bit above `HI_W-1`. Bits 8 and up of a write to a low register are dropped.
- R8: If a load and a readback are requested at the same edge, neither one happens, the selector holds, and `err` is 1 for the following cycle only.
- R9: `empty_ofs` is {empty high, empty low} and `full_ofs` is {full high, full low}. Both are `log2(DEPTH)` bits wide and are updated in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared read/write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Offset access strobe, active low |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| wr_data | input | DATA_W | FIFO data input bus |
| rd_data | output | DATA_W | Readback word on the data output path |
| err | output | 1 | One-cycle flag for a load/readback clash |
| empty_ofs | output | log2(DEPTH) | Almost-empty threshold n |
| full_ofs | output | log2(DEPTH) | Almost-full threshold m |

## Verification
Most faults in this block are in the selector, and they do not show up at once. A selector that is off by one, skips a step, or advances on a blocked request still accepts writes. It only shows when a later write lands in the wrong half of `empty_ofs`/`full_ofs`, one cycle after that write, or when a readback returns the wrong register. The stimulus therefore mixes loads and readbacks, pauses with `ld_n` high, injects a clash, and then confirms through the next readbacks that the sequence resumed at the expected register. High-part truncation and zero-extension can be seen directly on `full_ofs` and on `rd_data` bits 8:2.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } ofs_sel_e;

    localparam int          LO_W   = 8;
    localparam logic [7:0]  DEF_LO = 8'h07;
endpackage

// File: rtl/ofs_access_ctl.sv
module ofs_access_ctl
    import ofs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ld_n,
    input  logic     wen1_n,
    input  logic     ren1_n,
    input  logic     ren2_n,
    output ofs_sel_e sel,
    output logic     wr_go,
    output logic     rd_go,
    output logic     err
);
    typedef struct packed {
        ofs_sel_e sel;
        logic     err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_req, rd_req, clash;
    logic [1:0] sel_inc;

    always_comb begin
        wr_req  = !ld_n && !wen1_n;
        rd_req  = !ld_n && !ren1_n && !ren2_n;
        clash   = wr_req && rd_req;
        wr_go   = wr_req && !clash;
        rd_go   = rd_req && !clash;
        sel_inc = ctl_q.sel + 2'd1;

        ctl_d     = ctl_q;
        ctl_d.err = clash;
        if (wr_go || rd_go) begin
            ctl_d.sel = ofs_sel_e'(sel_inc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{sel: SEL_E_LO, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sel = ctl_q.sel;
    assign err = ctl_q.err;

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go || rd_go) |=> (2'(ctl_q.sel) == 2'($past(ctl_q.sel) + 2'd1)));

    // R5
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(ctl_q.sel));

    // R8
    clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !wen1_n && !ren1_n && !ren2_n) |=> (err && $stable(ctl_q.sel)));
endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import ofs_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ofs_sel_e          sel,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);
    localparam int HI_W    = OFS_W - LO_W;
    localparam int HI_KEEP = (HI_W > 0) ? HI_W : 1;

    typedef struct packed {
        logic [LO_W-1:0]    e_lo;
        logic [HI_KEEP-1:0] e_hi;
        logic [LO_W-1:0]    f_lo;
        logic [HI_KEEP-1:0] f_hi;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [HI_KEEP-1:0] hi_in;
    logic unused_bits;

    assign unused_bits = ^wr_data;

    generate
        if (HI_W > 0) begin : g_hi
            assign hi_in     = wr_data[HI_KEEP-1:0];
            assign empty_ofs = {bank_q.e_hi, bank_q.e_lo};
            assign full_ofs  = {bank_q.f_hi, bank_q.f_lo};
        end else begin : g_nohi
            assign hi_in     = '0;
            assign empty_ofs = bank_q.e_lo;
            assign full_ofs  = bank_q.f_lo;
        end
    endgenerate

    always_comb begin
        bank_d = bank_q;
        if (wr_go) begin
            unique case (sel)
                SEL_E_LO: bank_d.e_lo = wr_data[LO_W-1:0];
                SEL_E_HI: bank_d.e_hi = hi_in;
                SEL_F_LO: bank_d.f_lo = wr_data[LO_W-1:0];
                SEL_F_HI: bank_d.f_hi = hi_in;
            endcase
        end
        unique case (sel)
            SEL_E_LO: rd_word = DATA_W'(bank_q.e_lo);
            SEL_E_HI: rd_word = DATA_W'(bank_q.e_hi);
            SEL_F_LO: rd_word = DATA_W'(bank_q.f_lo);
            SEL_F_HI: rd_word = DATA_W'(bank_q.f_hi);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '{e_lo: DEF_LO, e_hi: '0, f_lo: DEF_LO, f_hi: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    // R4
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R9
    one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> ($stable(empty_ofs) || $stable(full_ofs)));
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
    import ofs_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_n,
    input  logic                     wen1_n,
    input  logic                     ren1_n,
    input  logic                     ren2_n,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     err,
    output logic [$clog2(DEPTH)-1:0] empty_ofs,
    output logic [$clog2(DEPTH)-1:0] full_ofs
);
    localparam int OFS_W = $clog2(DEPTH);

    ofs_sel_e          sel;
    logic              wr_go, rd_go;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_d, rd_q;

    ofs_access_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_n   (ld_n),
        .wen1_n (wen1_n),
        .ren1_n (ren1_n),
        .ren2_n (ren2_n),
        .sel    (sel),
        .wr_go  (wr_go),
        .rd_go  (rd_go),
        .err    (err)
    );

    ofs_store #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .wr_go     (wr_go),
        .wr_data   (wr_data),
        .rd_word   (rd_word),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_go) begin
            rd_d = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_go, rd_go}));

    // R6
    rd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> ($stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: tb/ofs_regfile_bench.sv
module ofs_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_n = 1'b1, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       err;
    logic [9:0] empty_ofs, full_ofs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ofs_regfile u_ofs_regfile (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .wr_data(wr_data),
        .rd_data(rd_data), .err(err), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    typedef struct packed {
        logic       ld_n;
        logic       wen1_n;
        logic       ren1_n;
        logic       ren2_n;
        logic [8:0] data;
        logic [9:0] exp_e;
        logic [9:0] exp_f;
        logic [8:0] exp_rd;
        logic       exp_err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b1,1'b1, 9'h1A5, 10'h0A5, 10'h007, 9'h000, 1'b0}, // R2 empty low
        '{1'b0,1'b0,1'b1,1'b1, 9'h1F3, 10'h3A5, 10'h007, 9'h000, 1'b0}, // R3 R9 empty high
        '{1'b1,1'b0,1'b1,1'b1, 9'h0FF, 10'h3A5, 10'h007, 9'h000, 1'b0}, // R4 ld high
        '{1'b0,1'b1,1'b1,1'b1, 9'h0FF, 10'h3A5, 10'h007, 9'h000, 1'b0}, // R4 no-op
        '{1'b0,1'b0,1'b1,1'b1, 9'h012, 10'h3A5, 10'h012, 9'h000, 1'b0}, // R5 resume
        '{1'b0,1'b0,1'b1,1'b1, 9'h1FE, 10'h3A5, 10'h212, 9'h000, 1'b0}, // R7 truncate
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h3A5, 10'h212, 9'h0A5, 1'b0}, // R3 wrap, R6
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h3A5, 10'h212, 9'h003, 1'b0}, // R6
        '{1'b0,1'b0,1'b0,1'b0, 9'h055, 10'h3A5, 10'h212, 9'h003, 1'b1}, // R8 clash
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h3A5, 10'h212, 9'h012, 1'b0}, // R8 sel kept
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h3A5, 10'h212, 9'h002, 1'b0}, // R7 zero ext
        '{1'b1,1'b1,1'b0,1'b0, 9'h000, 10'h3A5, 10'h212, 9'h002, 1'b0}, // R4 R6 no read
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h3A5, 10'h212, 9'h0A5, 1'b0}, // R3 wrap again
        '{1'b0,1'b0,1'b1,1'b1, 9'h0C1, 10'h1A5, 10'h212, 9'h0A5, 1'b0}, // R5 shared
        '{1'b0,1'b1,1'b0,1'b1, 9'h000, 10'h1A5, 10'h212, 9'h0A5, 1'b0}, // R6 one enable
        '{1'b0,1'b1,1'b0,1'b0, 9'h000, 10'h1A5, 10'h212, 9'h012, 1'b0}  // R6 R5 sel 2
    };

    task automatic chk(input string req, input string what, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    task automatic drive(input logic l, input logic w, input logic r1, input logic r2,
                         input logic [8:0] d);
        ld_n = l; wen1_n = w; ren1_n = r1; ren2_n = r2; wr_data = d;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 during reset
        chk("R1", "empty_ofs", int'(empty_ofs), 'h007);
        chk("R1", "full_ofs", int'(full_ofs), 'h007);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "err", int'(err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ld_n, TBL[i].wen1_n, TBL[i].ren1_n, TBL[i].ren2_n, TBL[i].data);
            @(negedge clk);
            chk($sformatf("row%0d", i), "empty_ofs", int'(empty_ofs), int'(TBL[i].exp_e));
            chk($sformatf("row%0d", i), "full_ofs", int'(full_ofs), int'(TBL[i].exp_f));
            chk($sformatf("row%0d", i), "rd_data", int'(rd_data), int'(TBL[i].exp_rd));
            chk($sformatf("row%0d", i), "err", int'(err), int'(TBL[i].exp_err));
        end
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        @(negedge clk);
        // R8 err lasts one cycle only, already low after clash row; recheck idle
        chk("R8", "err idle", int'(err), 0);

        // R1 reset mid-sequence restores defaults and selector
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "empty_ofs after reset", int'(empty_ofs), 'h007);
        chk("R1", "full_ofs after reset", int'(full_ofs), 'h007);
        chk("R1", "rd_data after reset", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 9'h033);
        @(negedge clk);
        chk("R1", "selector at empty low", int'(empty_ofs), 'h033);
        chk("R9", "full untouched", int'(full_ofs), 'h007);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        @(negedge clk);
        chk("R6", "read empty high default", int'(rd_data), 0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
        @(negedge clk);
        chk("R6", "read full low default", int'(rd_data), 'h007);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 9'h000);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule